// File: doc/BRIEF.md
# Dual Context Frame-Synchronized Register Bank

This block stores two complete sets of image-timing and readout-control parameters, called context A and context B, and drives one of them to the readout logic. A host writes either set at any time through a simple address/data/strobe port. A select flag, kept in its own register, names the wanted context. The block moves that choice onto its outputs only when a frame-start pulse arrives, so the readout datapath never sees a parameter set change within a frame.

The whole set is switched at once, with no per-register shadow copies. Most fields come from the newly chosen context in the frame that follows the boundary. The exposure group (shutter total and the first pixel-control voltage setting) lags by one more frame: at each frame start it loads the context that was active during the frame just ending. A few fields pack the A and B copies into one register word, in separate bit fields.

Top module: `dual_ctx_bank`

## Requirements
- R1: The context select flag is bit 15 of address 0x07 (0 = context A, 1 = context B). It resets to 0 and changes only when that address is written.
- R2: `active_ctx` changes only on a clock edge where `frame_start` is high. It then takes the select flag as it stood before that edge, and the new value is visible from the next cycle.
- R3: At a frame-start edge the main group outputs load the register contents of the newly active context as they stood before that edge. A write on the same edge as `frame_start` appears only at the following frame start.
- R4: Separate address pairs (A/B) hold column start 0x01/0xC9 (data bits [9:0]), row start 0x02/0xCA ([8:0]), window height 0x03/0xCB ([8:0]), window width 0x04/0xCC ([9:0]) and read mode 0x0D/0x0E ([5:0]). Higher data bits are dropped.
- R5: Address 0x0F holds the high-dynamic-range enable (A in bit 0, B in bit 8). Address 0x1C holds the ADC resolution code (A in bits [1:0], B in bits [9:8]). A write to either address updates both contexts' fields.
- R6: Shutter total (0x0B/0xD2, bits [14:0]) and pixel voltage control 1 (0x31/0x39, bits [6:0]) load, at each frame start, the context that was active before that edge. After a context change they therefore switch one frame later than the main group.
- R7: Between frame starts every parameter output and `active_ctx` hold their values, whatever is written.
- R8: Writes to addresses other than those in R1, R4, R5 and R6 change no stored value and no output.
- R9: After reset all parameter outputs are 0 and `active_ctx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| active_ctx | output | 1 | Context presented on the outputs (0 = A) |
| col_start | output | 10 | Active column start |
| row_start | output | 9 | Active row start |
| win_height | output | 9 | Active window height |
| win_width | output | 10 | Active window width |
| read_mode | output | 6 | Active read-mode field |
| hdr_en | output | 1 | Active high-dynamic-range enable |
| adc_res | output | 2 | Active ADC resolution code |
| shutter_total | output | 15 | Exposure total, one-frame-lagged context |
| v1_ctrl | output | 7 | Pixel voltage control 1, one-frame-lagged context |

## Verification
The bench runs a sequence of context choices across frames. At each boundary it checks that the main group follows the new choice and the exposure group follows the previous one. A design without the extra lag, or with the lag on the wrong group, gives the wrong shutter value on the first frame after each switch. Writes placed mid-frame, and on the same edge as the frame pulse, must not reach the outputs early; a bank that muxed combinationally or sampled after the write would leak them. The bench toggles the select flag and restores it within a frame, so a design that switches on the write, not at the boundary, flips context. It also covers packed A/B fields, dropped upper data bits and unmapped addresses.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
   localparam int NUM_CTX = 2;

   // control and packed-field addresses
   localparam logic [7:0] ADR_SEL = 8'h07;
   localparam logic [7:0] ADR_HDR = 8'h0F;
   localparam logic [7:0] ADR_ADC = 8'h1C;
   localparam int SEL_BIT    = 15;
   localparam int PACK_B_LSB = 8;   // B copy of a packed field starts here

   // per-context address pairs, index = context (0 = A, 1 = B)
   localparam logic [NUM_CTX-1:0][7:0] ADR_COL = {8'hC9, 8'h01};
   localparam logic [NUM_CTX-1:0][7:0] ADR_ROW = {8'hCA, 8'h02};
   localparam logic [NUM_CTX-1:0][7:0] ADR_HGT = {8'hCB, 8'h03};
   localparam logic [NUM_CTX-1:0][7:0] ADR_WID = {8'hCC, 8'h04};
   localparam logic [NUM_CTX-1:0][7:0] ADR_RDM = {8'h0E, 8'h0D};
   localparam logic [NUM_CTX-1:0][7:0] ADR_SHT = {8'hD2, 8'h0B};
   localparam logic [NUM_CTX-1:0][7:0] ADR_V1  = {8'h39, 8'h31};
endpackage

// File: rtl/dcb_store.sv
module dcb_store
   import dcb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int COL_W  = 10,
   parameter int ROW_W  = 9,
   parameter int HGT_W  = 9,
   parameter int WID_W  = 10,
   parameter int RM_W   = 6,
   parameter int ADC_W  = 2,
   parameter int SHT_W  = 15,
   parameter int V1_W   = 7,
   localparam int MAIN_W = COL_W + ROW_W + HGT_W + WID_W + RM_W + 1 + ADC_W,
   localparam int LAG_W  = SHT_W + V1_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   output logic                             sel,
   output logic [NUM_CTX-1:0][MAIN_W-1:0]   main_set,
   output logic [NUM_CTX-1:0][LAG_W-1:0]    lag_set
);

   logic hit_sel, hit_hdr, hit_adc;
   assign hit_sel = wr_en && (wr_addr == ADDR_W'(ADR_SEL));
   assign hit_hdr = wr_en && (wr_addr == ADDR_W'(ADR_HDR));
   assign hit_adc = wr_en && (wr_addr == ADDR_W'(ADR_ADC));

   always_ff @(posedge clk) begin
      if (!rst_n)       sel <= 1'b0;
      else if (hit_sel) sel <= wr_data[SEL_BIT];
   end

   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit_sel |=> sel == $past(wr_data[SEL_BIT])); // R1
   AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_sel |=> $stable(sel)); // R1

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic [COL_W-1:0] col_q;
      logic [ROW_W-1:0] row_q;
      logic [HGT_W-1:0] hgt_q;
      logic [WID_W-1:0] wid_q;
      logic [RM_W-1:0]  rdm_q;
      logic             hdr_q;
      logic [ADC_W-1:0] adc_q;
      logic [SHT_W-1:0] sht_q;
      logic [V1_W-1:0]  v1_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            col_q <= '0; row_q <= '0; hgt_q <= '0; wid_q <= '0;
            rdm_q <= '0; hdr_q <= 1'b0; adc_q <= '0;
            sht_q <= '0; v1_q  <= '0;
         end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_COL[c])) col_q <= wr_data[COL_W-1:0];
            if (wr_addr == ADDR_W'(ADR_ROW[c])) row_q <= wr_data[ROW_W-1:0];
            if (wr_addr == ADDR_W'(ADR_HGT[c])) hgt_q <= wr_data[HGT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_WID[c])) wid_q <= wr_data[WID_W-1:0];
            if (wr_addr == ADDR_W'(ADR_RDM[c])) rdm_q <= wr_data[RM_W-1:0];
            if (wr_addr == ADDR_W'(ADR_SHT[c])) sht_q <= wr_data[SHT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_V1[c]))  v1_q  <= wr_data[V1_W-1:0];
            if (hit_hdr) hdr_q <= wr_data[c*PACK_B_LSB];
            if (hit_adc) adc_q <= wr_data[c*PACK_B_LSB +: ADC_W];
         end
      end

      assign main_set[c] = {col_q, row_q, hgt_q, wid_q, rdm_q, hdr_q, adc_q};
      assign lag_set[c]  = {sht_q, v1_q};

      AST_PACKED_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
         hit_hdr |=> hdr_q == $past(wr_data[c*PACK_B_LSB])); // R5
   end

   // elaboration checks
   if (ADDR_W < 8) begin : g_bad_addr
      $error("dcb_store: ADDR_W must be at least 8");
   end
   if (DATA_W <= SEL_BIT || DATA_W < PACK_B_LSB + ADC_W) begin : g_bad_data
      $error("dcb_store: DATA_W too narrow for select or packed fields");
   end
   if (ADC_W > PACK_B_LSB) begin : g_bad_adc
      $error("dcb_store: ADC_W overlaps the B copy of the packed field");
   end
   if (COL_W > DATA_W || ROW_W > DATA_W || HGT_W > DATA_W || WID_W > DATA_W ||
       RM_W > DATA_W || SHT_W > DATA_W || V1_W > DATA_W) begin : g_bad_field
      $error("dcb_store: a field is wider than DATA_W");
   end
endmodule

// File: rtl/dcb_frame_stage.sv
module dcb_frame_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start,
   input  logic         pick,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)           q <= '0;
      else if (frame_start) q <= pick ? in_b : in_a;
   end

   AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(q)); // R7

   if (W < 1) begin : g_bad_w
      $error("dcb_frame_stage: W must be positive");
   end
endmodule

// File: rtl/dual_ctx_bank.sv
module dual_ctx_bank
   import dcb_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int COL_W   = 10,
   parameter int ROW_W   = 9,
   parameter int HGT_W   = 9,
   parameter int WID_W   = 10,
   parameter int RM_W    = 6,
   parameter int ADC_W   = 2,
   parameter int SHT_W   = 15,
   parameter int V1_W    = 7,
   parameter bit SHT_LAG = 1'b1,
   localparam int MAIN_W = COL_W + ROW_W + HGT_W + WID_W + RM_W + 1 + ADC_W,
   localparam int LAG_W  = SHT_W + V1_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_start,
   output logic              active_ctx,
   output logic [COL_W-1:0]  col_start,
   output logic [ROW_W-1:0]  row_start,
   output logic [HGT_W-1:0]  win_height,
   output logic [WID_W-1:0]  win_width,
   output logic [RM_W-1:0]   read_mode,
   output logic              hdr_en,
   output logic [ADC_W-1:0]  adc_res,
   output logic [SHT_W-1:0]  shutter_total,
   output logic [V1_W-1:0]   v1_ctrl
);

   logic                           sel_w;
   logic [NUM_CTX-1:0][MAIN_W-1:0] main_set;
   logic [NUM_CTX-1:0][LAG_W-1:0]  lag_set;
   logic [MAIN_W-1:0]              main_q;
   logic [LAG_W-1:0]               lag_q;
   logic                           lag_pick;

   dcb_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W),
      .HGT_W(HGT_W), .WID_W(WID_W), .RM_W(RM_W), .ADC_W(ADC_W),
      .SHT_W(SHT_W), .V1_W(V1_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sel(sel_w), .main_set(main_set), .lag_set(lag_set)
   );

   // active context flag: a one-bit frame stage choosing constant 0 or 1
   dcb_frame_stage #(.W(1)) i_ctx_stage (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pick(sel_w),
      .in_a(1'b0), .in_b(1'b1), .q(active_ctx)
   );

   dcb_frame_stage #(.W(MAIN_W)) i_main_stage (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pick(sel_w),
      .in_a(main_set[0]), .in_b(main_set[1]), .q(main_q)
   );

   // exposure group: lagged by one frame, or aligned with the main group
   if (SHT_LAG) begin : g_lag
      assign lag_pick = active_ctx;
      AST_LAG_PREV_CTX: assert property (@(posedge clk) disable iff (!rst_n)
         frame_start |=> lag_q == $past(lag_set[active_ctx])); // R6
   end else begin : g_nolag
      assign lag_pick = sel_w;
   end

   dcb_frame_stage #(.W(LAG_W)) i_lag_stage (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pick(lag_pick),
      .in_a(lag_set[0]), .in_b(lag_set[1]), .q(lag_q)
   );

   assign {col_start, row_start, win_height, win_width,
           read_mode, hdr_en, adc_res} = main_q;
   assign {shutter_total, v1_ctrl} = lag_q;

   AST_CTX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> active_ctx == $past(sel_w)); // R2
   AST_CTX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(active_ctx)); // R2
   AST_MAIN_NEW_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> main_q == $past(main_set[sel_w])); // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(col_start) && $stable(shutter_total)); // R7
endmodule

// File: tb/test_dual_ctx_bank.sv
module test_dual_ctx_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [15:0] wr_data;
   logic        frame_start;
   logic        active_ctx;
   logic [9:0]  col_start;
   logic [8:0]  row_start;
   logic [8:0]  win_height;
   logic [9:0]  win_width;
   logic [5:0]  read_mode;
   logic        hdr_en;
   logic [1:0]  adc_res;
   logic [14:0] shutter_total;
   logic [6:0]  v1_ctrl;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_ctx_bank i_dual_ctx_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .active_ctx(active_ctx),
      .col_start(col_start), .row_start(row_start), .win_height(win_height),
      .win_width(win_width), .read_mode(read_mode), .hdr_en(hdr_en),
      .adc_res(adc_res), .shutter_total(shutter_total), .v1_ctrl(v1_ctrl)
   );

   // context values preloaded into the bank
   localparam logic [9:0]  COL_A = 10'h011, COL_B = 10'h2C9;
   localparam logic [14:0] SHT_A = 15'h1234, SHT_B = 15'h0ABC;

   // frame walk: {select written, expected active_ctx, expected shutter from B}
   localparam logic [2:0] WALK [6] = '{3'b000, 3'b110, 3'b111,
                                       3'b001, 3'b110, 3'b001};

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fs();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; frame_start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 / R1: reset state
      check("R9 col", 32'(col_start), 0);
      check("R9 shutter", 32'(shutter_total), 0);
      check("R1 reset ctx", 32'(active_ctx), 0);

      // preload both contexts; col A carries junk upper bits (R4)
      wr(8'h01, 16'hFC11); wr(8'hC9, 16'h02C9);
      wr(8'h02, 16'h0022); wr(8'hCA, 16'h00CA);
      wr(8'h03, 16'h0033); wr(8'hCB, 16'h01CB);
      wr(8'h04, 16'h0044); wr(8'hCC, 16'h03CC);
      wr(8'h0D, 16'h0015); wr(8'h0E, 16'h002E);
      wr(8'h0F, 16'h0100); wr(8'h1C, 16'h0302);
      wr(8'h0B, 16'h1234); wr(8'hD2, 16'h0ABC);
      wr(8'h31, 16'h0021); wr(8'h39, 16'h0039);
      check("R7 no frame yet", 32'(col_start), 0);

      // table walk: R2 main follows select, R6 shutter follows previous
      for (int i = 0; i < 6; i++) begin
         wr(8'h07, {WALK[i][2], 15'h0});
         fs();
         check("R2 walk ctx", 32'(active_ctx), 32'(WALK[i][1]));
         check("R3 walk col", 32'(col_start), 32'(WALK[i][1] ? COL_B : COL_A));
         check("R6 walk shutter", 32'(shutter_total),
               32'(WALK[i][0] ? SHT_B : SHT_A));
      end

      // settle on context A, all fields (R4, R5)
      fs();
      check("R4 col A", 32'(col_start), 32'h011);
      check("R4 row A", 32'(row_start), 32'h022);
      check("R4 hgt A", 32'(win_height), 32'h033);
      check("R4 wid A", 32'(win_width), 32'h044);
      check("R4 rdm A", 32'(read_mode), 32'h15);
      check("R5 hdr A", 32'(hdr_en), 0);
      check("R5 adc A", 32'(adc_res), 2);
      check("R6 sht A", 32'(shutter_total), 32'h1234);
      check("R6 v1 A", 32'(v1_ctrl), 32'h21);

      // switch to B: not before the frame start (R2)
      wr(8'h07, 16'h8000);
      check("R2 midframe ctx", 32'(active_ctx), 0);
      fs();
      check("R2 ctx B", 32'(active_ctx), 1);
      check("R4 col B", 32'(col_start), 32'h2C9);
      check("R4 row B", 32'(row_start), 32'h0CA);
      check("R4 hgt B", 32'(win_height), 32'h1CB);
      check("R4 wid B", 32'(win_width), 32'h3CC);
      check("R4 rdm B", 32'(read_mode), 32'h2E);
      check("R5 hdr B", 32'(hdr_en), 1);
      check("R5 adc B", 32'(adc_res), 3);
      check("R6 sht lag", 32'(shutter_total), 32'h1234);
      check("R6 v1 lag", 32'(v1_ctrl), 32'h21);
      fs();
      check("R6 sht B", 32'(shutter_total), 32'h0ABC);
      check("R6 v1 B", 32'(v1_ctrl), 32'h39);

      // mid-frame write to the active context (R7, R3)
      wr(8'hC9, 16'h0155);
      check("R7 midframe col", 32'(col_start), 32'h2C9);
      fs();
      check("R3 new col", 32'(col_start), 32'h155);

      // write on the same edge as frame_start (R3)
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'hC9; wr_data = 16'h00AA; frame_start = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; frame_start = 1'b0;
      check("R3 same edge col", 32'(col_start), 32'h155);
      fs();
      check("R3 next frame col", 32'(col_start), 32'h0AA);

      // select toggled and restored within a frame (R2)
      wr(8'h07, 16'h0000); wr(8'h07, 16'h8000);
      fs();
      check("R2 toggled ctx", 32'(active_ctx), 1);

      // unmapped addresses (R8)
      wr(8'h05, 16'hFFFF); wr(8'hC8, 16'hFFFF);
      wr(8'h00, 16'hFFFF); wr(8'hD3, 16'hFFFF);
      fs();
      check("R8 ctx", 32'(active_ctx), 1);
      check("R8 col", 32'(col_start), 32'h0AA);
      check("R8 row", 32'(row_start), 32'h0CA);
      check("R8 wid", 32'(win_width), 32'h3CC);
      check("R8 sht", 32'(shutter_total), 32'h0ABC);

      // packed write changes both copies (R5)
      wr(8'h0F, 16'h0001);
      fs();
      check("R5 hdr B cleared", 32'(hdr_en), 0);
      wr(8'h07, 16'h0000);
      fs();
      check("R5 hdr A set", 32'(hdr_en), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule